// File: doc/BRIEF.md
# Debug Port Serial Receiver

This block is the receiving front end of a bit-serial development port. A short while after reset it strobes its own serial data line once and keeps that level as the clocking choice. A high level selects self-clocked operation: one bit is taken on every system clock edge. A low level selects operation from an external serial clock. That clock and the data line are resynchronised into the system clock domain, and one bit is taken on each rising edge of the serial clock.

Once the clock choice is made, the receiver waits out a guard interval. It then needs to see the line low before it treats any high bit as the start of a frame. Each frame carries a start bit, a mode bit and a control bit, followed by a payload.

- A set mode bit marks a short 10-bit frame. Its seven payload bits update a trap-enable control register. The control bit selects which fields take those bits: the seven trap-enable bits, or the VSYNC bit together with six breakpoint bits.
- A clear mode bit marks a long 35-bit frame. Its 32 payload bits are presented on a word output with a one-cycle valid strobe.

The serial output is the ready handshake back to the debug tool. It is low while the receiver is waiting for a start bit and high at all other times.

Top module: `dbg_serial_rx`

State machine states and transitions (receiver):
- HOLD: after reset. On the 16th clock it goes to WAIT_IDLE if the line level is high, or to SCAN if the line level is low.
- WAIT_IDLE: goes to SCAN on a low line level.
- SCAN: goes to MODE when a sampled bit is 1 (the start bit).
- MODE: goes to CTRL on the next sampled bit.
- CTRL: goes to DATA on the next sampled bit.
- DATA: goes to DONE on the bit that completes the frame length.
- DONE: goes to SCAN after one cycle.

## Requirements
- R1: While reset is asserted, and after reset is released, sdo_o is 1, word_valid_o is 0, and trap_en_o, vsync_o and bkpt_o are all zero.
- R2: The clock scheme is fixed on the 8th rising clk edge after reset is released. If sdi_i is 1 there, the receiver is self-clocked. If it is 0, the receiver uses sclk_i. The choice does not change until the next reset.
- R3: In self-clocked mode, one bit of sdi_i is sampled on every rising clk edge.
- R4: In clocked mode, sclk_i and sdi_i each pass through a two-flop synchronizer. A bit is taken only on a detected rising edge of the synchronized serial clock. Activity on sdi_i without sclk_i edges receives nothing.
- R5: sdo_o stays 1 through the first 15 clk edges after reset is released. If the line is low at the 16th edge, sdo_o is 0 after that edge.
- R6: If the line is high at the 16th edge, sdo_o stays 1 until the line has been seen low. Only after that does scanning for a start bit begin.
- R7: sdo_o is 0 only while the receiver scans for a start bit. It goes to 1 from the sampled start bit (value 1) through one cycle after the last bit of the frame.
- R8: The bits arrive in the order start, mode, control. A mode bit of 1 makes the frame 10 bits in total. A mode bit of 0 makes it 35 bits in total.
- R9: For a short frame with control bit 0, the seven payload bits load trap_en_o. The first payload bit received becomes bit 6.
- R10: For a short frame with control bit 1, the first payload bit loads vsync_o. The remaining six payload bits load bkpt_o, the first of them becoming bit 5. trap_en_o is unchanged.
- R11: For a long frame, word_o holds the 32 payload bits, the first received in bit 31. word_valid_o is 1 for exactly the one cycle after the last bit is sampled. A short frame raises no strobe.
- R12: trap_en_o, vsync_o and bkpt_o change only at the end of a short frame. Long frames leave them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Asynchronous reset, active high |
| sdi_i | input | 1 | Serial data in; its level also sets the clock scheme |
| sclk_i | input | 1 | External serial clock, used in clocked mode |
| sdo_o | output | 1 | Ready handshake: 0 = waiting for a start bit |
| trap_en_o | output | 7 | Trap-enable field of the control register |
| vsync_o | output | 1 | VSYNC bit of the control register |
| bkpt_o | output | 6 | Breakpoint bits of the control register |
| word_o | output | 32 | Payload of the last long frame |
| word_valid_o | output | 1 | One-cycle strobe marking a new word_o |

## Verification
Some properties are checked on every cycle:
- the clock choice stays frozen once the strap edge has passed;
- the ready level never drops before the guard interval ends;
- a sampled start bit always raises sdo_o on the next cycle;
- the bit count in DATA stays below the frame length;
- clocked-mode sample ticks never occur on consecutive cycles;
- the word strobe lasts a single cycle;
- the control register is quiet outside the DONE state.

Other behaviour only the bench scenarios can show: the strap outcome, the exact guard edge, the wait for an idle line, the payload bit order and field routing for each control value, and receiving nothing when the serial clock is idle.

// File: rtl/dbgrx_pkg.sv
package dbgrx_pkg;

    typedef enum logic [2:0] {
        ST_HOLD      = 3'd0,
        ST_WAIT_IDLE = 3'd1,
        ST_SCAN      = 3'd2,
        ST_MODE      = 3'd3,
        ST_CTRL      = 3'd4,
        ST_DATA      = 3'd5,
        ST_DONE      = 3'd6
    } rx_state_e;

endpackage

// File: rtl/dbgrx_strap.sv
module dbgrx_strap #(
    parameter int STRAP_CYC = 8,
    parameter int GUARD_CYC = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic sdi_i,
    output logic self_mode_o,
    output logic guard_hit_o,
    output logic guard_done_o
);
    localparam int CW = $clog2(GUARD_CYC + 1);
    localparam logic [CW-1:0] STRAP_AT = CW'(STRAP_CYC - 1);
    localparam logic [CW-1:0] GUARD_AT = CW'(GUARD_CYC - 1);
    localparam logic [CW-1:0] GUARD_END = CW'(GUARD_CYC);

    logic [CW-1:0] cnt_q;
    logic          self_q;

    // Counts clk edges since reset release and saturates at the guard length.
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            cnt_q  <= '0;
            self_q <= 1'b0;
        end else begin
            if (cnt_q != GUARD_END) begin
                cnt_q <= cnt_q + 1'b1;
            end
            if (cnt_q == STRAP_AT) begin
                self_q <= sdi_i;
            end
        end
    end

    assign self_mode_o  = self_q;
    assign guard_hit_o  = (cnt_q == GUARD_AT);
    assign guard_done_o = (cnt_q == GUARD_END);

    // R2: once the strap edge is behind, the clock choice is frozen
    p_strap_frozen_r2: assert property (@(posedge clk) disable iff (rst)
        (cnt_q > STRAP_AT) |=> $stable(self_q));

endmodule

// File: rtl/dbgrx_bitsrc.sv
module dbgrx_bitsrc #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic self_mode_i,
    input  logic sdi_i,
    input  logic sclk_i,
    output logic tick_o,
    output logic bit_o,
    output logic lvl_o
);
    localparam int TOP = SYNC_STAGES - 1;

    logic [TOP:0] sclk_sh;
    logic [TOP:0] sdi_sh;
    logic         sclk_prev;
    logic         sclk_rise;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            sclk_sh   <= '0;
            sdi_sh    <= '0;
            sclk_prev <= 1'b0;
        end else begin
            sclk_sh   <= {sclk_sh[TOP-1:0], sclk_i};
            sdi_sh    <= {sdi_sh[TOP-1:0], sdi_i};
            sclk_prev <= sclk_sh[TOP];
        end
    end

    assign sclk_rise = sclk_sh[TOP] & ~sclk_prev;

    // Self-clocked: every edge carries a bit straight off the pin.
    // Clocked: only a synchronized serial-clock rise carries a bit.
    always_comb begin
        if (self_mode_i) begin
            tick_o = 1'b1;
            bit_o  = sdi_i;
        end else begin
            tick_o = sclk_rise;
            bit_o  = sdi_sh[TOP];
        end
        lvl_o = bit_o;
    end

    // R4: clocked-mode sample ticks come from edges, never two cycles in a row
    p_tick_edge_r4: assert property (@(posedge clk) disable iff (rst)
        (!self_mode_i && tick_o) |=> !tick_o);

endmodule

// File: rtl/dbgrx_frame.sv
module dbgrx_frame
    import dbgrx_pkg::*;
#(
    parameter int TRAP_BITS = 7,
    parameter int WORD_W    = 32
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   tick_i,
    input  logic                   bit_i,
    input  logic                   lvl_i,
    input  logic                   guard_hit_i,
    input  logic                   guard_done_i,
    output logic                   sdo_o,
    output logic [TRAP_BITS-1:0]   trap_en_o,
    output logic                   vsync_o,
    output logic [TRAP_BITS-2:0]   bkpt_o,
    output logic [WORD_W-1:0]      word_o,
    output logic                   word_valid_o
);
    localparam int HDR_BITS  = 3;
    localparam int SHORT_LEN = HDR_BITS + TRAP_BITS;
    localparam int LONG_LEN  = HDR_BITS + WORD_W;
    localparam int NW        = $clog2(LONG_LEN + 1);

    rx_state_e state_q, state_d;

    logic [LONG_LEN-1:0]  sr_q;
    logic [NW-1:0]        nbits_q;
    logic                 mode_q;
    logic                 ctrl_q;
    logic [TRAP_BITS-1:0] te_q;
    logic                 vs_q;
    logic [TRAP_BITS-2:0] bk_q;
    logic [NW-1:0]        frame_len;
    logic                 last_bit;
    logic                 take;

    assign frame_len = mode_q ? NW'(SHORT_LEN) : NW'(LONG_LEN);
    assign last_bit  = ((nbits_q + 1'b1) == frame_len);

    // State register
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            state_q <= ST_HOLD;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD:      if (guard_hit_i) state_d = lvl_i ? ST_WAIT_IDLE : ST_SCAN;
            ST_WAIT_IDLE: if (!lvl_i) state_d = ST_SCAN;
            ST_SCAN:      if (tick_i && bit_i) state_d = ST_MODE;
            ST_MODE:      if (tick_i) state_d = ST_CTRL;
            ST_CTRL:      if (tick_i) state_d = ST_DATA;
            ST_DATA:      if (tick_i && last_bit) state_d = ST_DONE;
            ST_DONE:      state_d = ST_SCAN;
            default:      state_d = ST_HOLD;
        endcase
    end

    // A bit enters the shift register on any tick of a frame in progress
    always_comb begin
        unique case (state_q)
            ST_SCAN:                   take = tick_i && bit_i;
            ST_MODE, ST_CTRL, ST_DATA: take = tick_i;
            default:                   take = 1'b0;
        endcase
    end

    // Frame datapath and control register
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            sr_q    <= '0;
            nbits_q <= '0;
            mode_q  <= 1'b0;
            ctrl_q  <= 1'b0;
            te_q    <= '0;
            vs_q    <= 1'b0;
            bk_q    <= '0;
        end else begin
            if (take) begin
                sr_q    <= {sr_q[LONG_LEN-2:0], bit_i};
                nbits_q <= (state_q == ST_SCAN) ? NW'(1) : nbits_q + 1'b1;
                if (state_q == ST_MODE) mode_q <= bit_i;
                if (state_q == ST_CTRL) ctrl_q <= bit_i;
            end
            if (state_q == ST_DONE && mode_q) begin
                if (ctrl_q) begin
                    {vs_q, bk_q} <= sr_q[TRAP_BITS-1:0];
                end else begin
                    te_q <= sr_q[TRAP_BITS-1:0];
                end
            end
        end
    end

    // Outputs
    always_comb begin
        sdo_o        = (state_q != ST_SCAN);
        word_valid_o = (state_q == ST_DONE) && !mode_q;
        word_o       = sr_q[WORD_W-1:0];
        trap_en_o    = te_q;
        vsync_o      = vs_q;
        bkpt_o       = bk_q;
    end

    // R5: ready is never signalled before the guard interval has elapsed
    p_ready_after_guard_r5: assert property (@(posedge clk) disable iff (rst)
        !sdo_o |-> guard_done_i);

    // R7: a sampled start bit drops ready on the next cycle
    p_busy_on_start_r7: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SCAN && tick_i && bit_i) |=> sdo_o);

    // R8: the payload count never reaches the selected frame length
    p_len_bound_r8: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DATA) |-> (nbits_q < frame_len));

    // R11: the word strobe lasts exactly one cycle
    p_strobe_single_r11: assert property (@(posedge clk) disable iff (rst)
        word_valid_o |=> !word_valid_o);

    // R12: control register moves only at the end of a frame
    p_tecr_quiet_r12: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_DONE) |=> $stable({trap_en_o, vsync_o, bkpt_o}));

endmodule

// File: rtl/dbg_serial_rx.sv
module dbg_serial_rx #(
    parameter int STRAP_CYC   = 8,
    parameter int GUARD_CYC   = 16,
    parameter int SYNC_STAGES = 2,
    parameter int TRAP_BITS   = 7,
    parameter int WORD_W      = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sdi_i,
    input  logic                 sclk_i,
    output logic                 sdo_o,
    output logic [TRAP_BITS-1:0] trap_en_o,
    output logic                 vsync_o,
    output logic [TRAP_BITS-2:0] bkpt_o,
    output logic [WORD_W-1:0]    word_o,
    output logic                 word_valid_o
);
    logic self_mode;
    logic guard_hit;
    logic guard_done;
    logic tick;
    logic bit_s;
    logic lvl;

    dbgrx_strap #(
        .STRAP_CYC (STRAP_CYC),
        .GUARD_CYC (GUARD_CYC)
    ) u_strap (
        .clk          (clk),
        .rst          (rst),
        .sdi_i        (sdi_i),
        .self_mode_o  (self_mode),
        .guard_hit_o  (guard_hit),
        .guard_done_o (guard_done)
    );

    dbgrx_bitsrc #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_bitsrc (
        .clk         (clk),
        .rst         (rst),
        .self_mode_i (self_mode),
        .sdi_i       (sdi_i),
        .sclk_i      (sclk_i),
        .tick_o      (tick),
        .bit_o       (bit_s),
        .lvl_o       (lvl)
    );

    dbgrx_frame #(
        .TRAP_BITS (TRAP_BITS),
        .WORD_W    (WORD_W)
    ) u_frame (
        .clk          (clk),
        .rst          (rst),
        .tick_i       (tick),
        .bit_i        (bit_s),
        .lvl_i        (lvl),
        .guard_hit_i  (guard_hit),
        .guard_done_i (guard_done),
        .sdo_o        (sdo_o),
        .trap_en_o    (trap_en_o),
        .vsync_o      (vsync_o),
        .bkpt_o       (bkpt_o),
        .word_o       (word_o),
        .word_valid_o (word_valid_o)
    );

endmodule

// File: tb/sim_dbg_serial_rx.sv
module sim_dbg_serial_rx;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sdi = 1'b0;
    logic        sclk = 1'b0;
    logic        sdo;
    logic [6:0]  trap_en;
    logic        vsync;
    logic [5:0]  bkpt;
    logic [31:0] word;
    logic        word_valid;

    int vec = 0;
    int bad = 0;
    int wv_cnt = 0;
    logic [31:0] wv_word = '0;

    logic [6:0] m_te = '0;
    logic       m_vs = 1'b0;
    logic [5:0] m_bk = '0;

    always #5 clk = ~clk;

    dbg_serial_rx u0 (
        .clk          (clk),
        .rst          (rst),
        .sdi_i        (sdi),
        .sclk_i       (sclk),
        .sdo_o        (sdo),
        .trap_en_o    (trap_en),
        .vsync_o      (vsync),
        .bkpt_o       (bkpt),
        .word_o       (word),
        .word_valid_o (word_valid)
    );

    always @(negedge clk) begin
        if (rst) wv_cnt <= 0;
        else if (word_valid) begin
            wv_cnt  <= wv_cnt + 1;
            wv_word <= word;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        vec++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [34:0] short_frame(input logic c, input logic [6:0] d);
        return {25'd0, 1'b1, 1'b1, c, d};
    endfunction

    function automatic logic [34:0] long_frame(input logic c, input logic [31:0] d);
        return {1'b1, 1'b0, c, d};
    endfunction

    task automatic model_short(input logic c, input logic [6:0] d);
        if (c) begin
            m_vs = d[6];
            m_bk = d[5:0];
        end else begin
            m_te = d;
        end
    endtask

    task automatic chk_regs(input string req);
        chk(trap_en == m_te, req, {25'd0, trap_en}, {25'd0, m_te});
        chk({vsync, bkpt} == {m_vs, m_bk}, req, {25'd0, vsync, bkpt}, {25'd0, m_vs, m_bk});
    endtask

    // Reset, hold strap level through the 8th edge after release
    task automatic do_reset(input logic strap);
        rst = 1'b1; sdi = strap; sclk = 1'b0;
        repeat (3) @(negedge clk);
        chk(sdo == 1'b1 && word_valid == 1'b0, "R1 reset handshake", {30'd0, sdo, word_valid}, 32'h2);
        chk(trap_en == 0 && vsync == 0 && bkpt == 0, "R1 reset regs", {18'd0, trap_en, vsync, bkpt}, 32'h0);
        rst = 1'b0;
        m_te = '0; m_vs = 1'b0; m_bk = '0;
        repeat (8) @(negedge clk);
    endtask

    // Self-clocked frame: one bit per clk edge
    task automatic send_self(input logic [34:0] bits, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            sdi = bits[i];
            @(negedge clk);
            if (i == n - 1) chk(sdo == 1'b1, "R7 busy after start", {31'd0, sdo}, 32'h1);
        end
    endtask

    task automatic self_short(input logic c, input logic [6:0] d);
        int w0;
        w0 = wv_cnt;
        send_self(short_frame(c, d), 10);
        chk(sdo == 1'b1, "R7 busy in final cycle", {31'd0, sdo}, 32'h1);
        sdi = 1'b0;
        @(negedge clk);
        chk(sdo == 1'b0, "R7 ready after short", {31'd0, sdo}, 32'h0);
        model_short(c, d);
        if (c) chk_regs("R10 vsync/bkpt load");
        else   chk_regs("R9 trap field load");
        chk(wv_cnt == w0, "R11 no strobe on short", wv_cnt, w0);
    endtask

    task automatic self_long(input logic c, input logic [31:0] d);
        send_self(long_frame(c, d), 35);
        chk(word_valid == 1'b1, "R11 strobe high", {31'd0, word_valid}, 32'h1);
        chk(word == d, "R11 word R3 R8", word, d);
        sdi = 1'b0;
        @(negedge clk);
        chk(word_valid == 1'b0, "R11 strobe single", {31'd0, word_valid}, 32'h0);
        chk(sdo == 1'b0, "R7 ready after long", {31'd0, sdo}, 32'h0);
        chk_regs("R12 regs unchanged by long");
    endtask

    // Clocked mode bit: data set, serial clock high for 4 clk, low for 4 clk
    task automatic sclk_bit(input logic b);
        sdi = b;
        repeat (4) @(negedge clk);
        sclk = 1'b1;
        repeat (4) @(negedge clk);
        sclk = 1'b0;
    endtask

    task automatic clk_frame(input logic [34:0] bits, input int n);
        for (int i = n - 1; i >= 0; i--) sclk_bit(bits[i]);
        sdi = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL R1 watchdog act=timeout exp=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed));

        // Self-clocked strap, guard with idle line (R2, R5)
        do_reset(1'b1);
        sdi = 1'b0;
        repeat (7) @(negedge clk);
        chk(sdo == 1'b1, "R5 not ready at edge 15", {31'd0, sdo}, 32'h1);
        @(negedge clk);
        chk(sdo == 1'b0, "R5 ready at edge 16", {31'd0, sdo}, 32'h0);
        chk_regs("R1 regs after release");

        // Directed frames
        self_short(1'b0, 7'h55);
        self_short(1'b1, 7'h7f);
        self_short(1'b1, 7'h00);
        self_short(1'b0, 7'h01);
        self_long(1'b0, 32'hdeadbeef);
        self_long(1'b1, 32'hffffffff);
        self_long(1'b0, 32'h00000001);

        // Random frames with random idle gaps
        for (int k = 0; k < 40; k++) begin
            int gap;
            gap = int'($urandom_range(0, 3));
            sdi = 1'b0;
            repeat (gap) @(negedge clk);
            if ($urandom_range(0, 1) == 1)
                self_short(1'($urandom_range(0, 1)), 7'($urandom()));
            else
                self_long(1'($urandom_range(0, 1)), $urandom());
        end

        // Line still high at guard end: wait for idle (R6)
        do_reset(1'b1);
        repeat (8) @(negedge clk);
        chk(sdo == 1'b1, "R6 held at edge 16", {31'd0, sdo}, 32'h1);
        repeat (4) @(negedge clk);
        chk(sdo == 1'b1, "R6 held at edge 20", {31'd0, sdo}, 32'h1);
        sdi = 1'b0;
        @(negedge clk);
        chk(sdo == 1'b0, "R6 ready after idle", {31'd0, sdo}, 32'h0);
        self_short(1'b0, 7'h2a);

        // Clocked strap (R2, R4)
        do_reset(1'b0);
        repeat (7) @(negedge clk);
        chk(sdo == 1'b1, "R5 clocked edge 15", {31'd0, sdo}, 32'h1);
        @(negedge clk);
        chk(sdo == 1'b0, "R5 clocked edge 16", {31'd0, sdo}, 32'h0);
        begin
            bit stayed;
            stayed = 1'b1;
            sdi = 1'b1;
            repeat (12) begin
                @(negedge clk);
                if (sdo != 1'b0) stayed = 1'b0;
            end
            chk(stayed, "R2 R4 no bits without sclk", {31'd0, stayed}, 32'h1);
            sdi = 1'b0;
            repeat (4) @(negedge clk);
        end
        begin
            int w0;
            w0 = wv_cnt;
            clk_frame(short_frame(1'b0, 7'h4b), 10);
            model_short(1'b0, 7'h4b);
            chk_regs("R4 R9 clocked short ctrl0");
            clk_frame(short_frame(1'b1, 7'h35), 10);
            model_short(1'b1, 7'h35);
            chk_regs("R4 R10 clocked short ctrl1");
            chk(wv_cnt == w0, "R11 clocked short no strobe", wv_cnt, w0);
            clk_frame(long_frame(1'b0, 32'h1234abcd), 35);
            chk(wv_cnt == w0 + 1, "R11 clocked long strobe count", wv_cnt, w0 + 1);
            chk(wv_word == 32'h1234abcd, "R4 R11 clocked word", wv_word, 32'h1234abcd);
            chk(sdo == 1'b0, "R7 clocked ready", {31'd0, sdo}, 32'h0);
            chk_regs("R12 clocked long leaves regs");
        end

        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

endmodule